// File: doc/BRIEF.md
# Calibrated ADC Code-to-Millivolt Converter

This block turns a raw 12-bit converter code into a voltage in millivolts. Two reference lines are kept, a big-scale line for high voltages and a small-scale line for low ones. Each line is fixed by two voltage points and two code points. A code is mapped onto the line picked by its channel number with a two-point linear interpolation, and a result below zero is forced to zero. For most channels the interpolated small-line voltage is then divided by a per-channel attenuation ratio, with rounding to nearest, to give the voltage at the pin. One channel returns the big-line voltage as it stands, and one returns the small-line voltage as it stands.

The two code points of each line can be trimmed. Each line takes a 16-bit trim word made of two offset-encoded bytes, captured on a load strobe. A request enters through a valid/ready handshake that carries the code, the channel and a packed ratio word. The result leaves as a one-cycle valid pulse with an error flag. Both divisions run on a single shared sequential divider that retires one quotient bit per cycle, so the input stays not-ready while a conversion is in flight.

Top module: `adc_volt_conv`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and both trim words read as 0x8080. With bytes of 128, every code point equals its nominal value times 4 (big 856/733, small 833/80).
- R2: A trimmed code point is (byte + nominal − 128) × 4. Code point 0 takes bits 7:0 of the trim word and code point 1 takes bits 15:8. A new word takes effect only in a cycle where `cal_load` is 1 (`cal_big_word` for the big line, `cal_small_word` for the small line).
- R3: The line voltage is mv1 + ((mv0 − mv1)·(code − a1)) / (a0 − a1). The division truncates toward zero. The big line uses mv0 = 4200 and mv1 = 3600; the small line uses mv0 = 1000 and mv1 = 100.
- R4: A line voltage below zero becomes 0.
- R5: Channel 5 returns the big-line voltage with no ratio applied. Channel 1 returns the small-line voltage with no ratio applied. Every other channel uses the small line.
- R6: For every other channel, `in_ratio` bits 31:16 hold the numerator N and bits 15:0 hold the denominator D. The result is (V·D + N/2) / N, where N/2 truncates.
- R7: When a0 equals a1 on the selected line, the result is 0 and `out_err` is 1.
- R8: On a ratio channel with N = 0, the result is 0 and `out_err` is 1. On channels 5 and 1 the ratio word has no effect.
- R9: `in_ready` is 0 from the accepting edge until the conversion is finished. Inputs presented during that time do not change the result.
- R10: `out_valid` is high for exactly one cycle. Counting rising edges after the accepting edge, it is visible after 1 edge for a zero-span error, after DIV_W+2 edges on the direct channels and for a zero-numerator error, and after 2·DIV_W+3 edges on ratio channels (50 and 99 with DIV_W = 48).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_load | input | 1 | Capture both trim words this cycle |
| cal_big_word | input | 16 | Big-line trim: byte 0 for point 0, byte 1 for point 1 |
| cal_small_word | input | 16 | Small-line trim: byte 0 for point 0, byte 1 for point 1 |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Converter idle and able to accept |
| in_code | input | CODE_W | Raw converter code |
| in_chan | input | CH_W | Channel number |
| in_ratio | input | 2*DVS_W | Packed ratio: numerator high half, denominator low half |
| out_valid | output | 1 | One-cycle result strobe |
| out_mv | output | DIV_W | Result in millivolts |
| out_err | output | 1 | Zero span or zero numerator; valid with out_valid |

## Verification
The result comes out after one of three fixed delays, depending on which path the request takes. It appears 1 edge after acceptance for a zero-span error. It appears after DIV_W+2 edges when only the interpolation divide runs, which covers the direct channels and a zero numerator. It appears after 2·DIV_W+3 edges when the ratio divide runs as well. For every request the bench works out which delay is due from its own model. It counts rising edges from the accepting edge, sampling on the falling edge, until `out_valid` shows, and then checks the count, the value and the flag. A sweep over codes, channels and three trim settings compares each result with an arithmetic model. While waiting, the bench can keep driving a different request and check that `in_ready` stays low.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  localparam int PT_W  = 16;
  localparam int ACC_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV1,
    ST_DIV2,
    ST_DONE
  } conv_st_t;

  // Trimmed code point: offset-encoded byte around 128, scaled by four.
  function automatic logic signed [PT_W-1:0] cal_point(input logic [7:0] b, input int nom);
    int t;
    t = int'({24'd0, b}) + nom - 128;
    return PT_W'(t * 4);
  endfunction

  // Magnitude of a signed accumulator value.
  function automatic logic [ACC_W-1:0] mag32(input logic signed [ACC_W-1:0] x);
    return x[ACC_W-1] ? ACC_W'(-x) : ACC_W'(x);
  endfunction

  // Dividend for round-to-nearest: volt * den + floor(num / 2).
  function automatic logic [47:0] round_scale(input logic [31:0] volt,
                                              input logic [15:0] den,
                                              input logic [15:0] num);
    return (48'(volt) * 48'(den)) + (48'(num) >> 1);
  endfunction

endpackage

// File: rtl/adc_cal_store.sv
module adc_cal_store #(
  parameter int NOM0 = 833,
  parameter int NOM1 = 80
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic [15:0]                           word,
  output logic signed [adc_conv_pkg::PT_W-1:0]  pt0,
  output logic signed [adc_conv_pkg::PT_W-1:0]  pt1
);
  logic [15:0] word_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_r <= 16'h8080;
    else if (load)  word_r <= word;
  end

  assign pt0 = adc_conv_pkg::cal_point(word_r[7:0],  NOM0);
  assign pt1 = adc_conv_pkg::cal_point(word_r[15:8], NOM1);

  // R2
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_r));

endmodule

// File: rtl/adc_seq_div.sv
module adc_seq_div #(
  parameter int DVD_W = 48,
  parameter int DS_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DS_W-1:0]  dvs,
  output logic [DVD_W-1:0] quo,
  output logic             fin
);
  localparam int CW = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_r, dvd_h;
  logic [DS_W-1:0]  rem_r, dvs_h;
  logic [CW-1:0]    cnt;
  logic             fin_r;
  logic [DS_W:0]    trial;
  logic             take;

  assign trial = {rem_r, quo_r[DVD_W-1]};
  assign take  = trial >= {1'b0, dvs_h};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r <= '0; rem_r <= '0; dvd_h <= '0; dvs_h <= '0;
      cnt   <= '0; fin_r <= 1'b0;
    end else if (start) begin
      quo_r <= dvd; rem_r <= '0; dvd_h <= dvd; dvs_h <= dvs;
      cnt   <= CW'(DVD_W); fin_r <= 1'b0;
    end else if (cnt != '0) begin
      quo_r <= {quo_r[DVD_W-2:0], take};
      rem_r <= take ? DS_W'(trial - {1'b0, dvs_h}) : trial[DS_W-1:0];
      cnt   <= cnt - 1'b1;
      fin_r <= (cnt == CW'(1));
    end else begin
      fin_r <= 1'b0;
    end
  end

  assign quo = quo_r;
  assign fin = fin_r;

  // R3 R6: quotient and remainder reconstruct the dividend
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> ((DVD_W+DS_W)'(quo_r) * (DVD_W+DS_W)'(dvs_h) + (DVD_W+DS_W)'(rem_r)
             == (DVD_W+DS_W)'(dvd_h)));

  // R3 R6
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (rem_r < dvs_h));

endmodule

// File: rtl/adc_volt_conv.sv
module adc_volt_conv #(
  parameter int CODE_W   = 12,
  parameter int CH_W     = 5,
  parameter int DVS_W    = 16,
  parameter int DIV_W    = 48,
  parameter int BIG_CH   = 5,
  parameter int SML_CH   = 1,
  parameter int BIG_MV0  = 4200,
  parameter int BIG_MV1  = 3600,
  parameter int SML_MV0  = 1000,
  parameter int SML_MV1  = 100,
  parameter int BIG_NOM0 = 856,
  parameter int BIG_NOM1 = 733,
  parameter int SML_NOM0 = 833,
  parameter int SML_NOM1 = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_load,
  input  logic [15:0]        cal_big_word,
  input  logic [15:0]        cal_small_word,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CODE_W-1:0]  in_code,
  input  logic [CH_W-1:0]    in_chan,
  input  logic [2*DVS_W-1:0] in_ratio,
  output logic               out_valid,
  output logic [DIV_W-1:0]   out_mv,
  output logic               out_err
);
  import adc_conv_pkg::*;

  localparam int DS_W = DVS_W + 1;

  conv_st_t state;
  logic [CODE_W-1:0]  code_r;
  logic [CH_W-1:0]    chan_r;
  logic [2*DVS_W-1:0] ratio_r;
  logic               neg_r, err_r;
  logic [DIV_W-1:0]   res_r;

  logic signed [PT_W-1:0] big_p0, big_p1, sml_p0, sml_p1, p0, p1;

  adc_cal_store #(.NOM0(BIG_NOM0), .NOM1(BIG_NOM1)) u_cal_big (
    .clk(clk), .rst_n(rst_n), .load(cal_load), .word(cal_big_word),
    .pt0(big_p0), .pt1(big_p1));

  adc_cal_store #(.NOM0(SML_NOM0), .NOM1(SML_NOM1)) u_cal_sml (
    .clk(clk), .rst_n(rst_n), .load(cal_load), .word(cal_small_word),
    .pt0(sml_p0), .pt1(sml_p1));

  // Line selection and bypass decode
  logic use_big, bypass;
  assign use_big = (chan_r == CH_W'(BIG_CH));
  assign bypass  = use_big || (chan_r == CH_W'(SML_CH));
  assign p0 = use_big ? big_p0 : sml_p0;
  assign p1 = use_big ? big_p1 : sml_p1;

  // Interpolation operands
  logic signed [31:0] mv_hi, mv_lo, code_s, p0_s, p1_s, prod;
  logic signed [DS_W-1:0] span_w;
  logic [DS_W-1:0] span_mag;
  logic span_zero;

  assign mv_hi  = use_big ? 32'(BIG_MV0) : 32'(SML_MV0);
  assign mv_lo  = use_big ? 32'(BIG_MV1) : 32'(SML_MV1);
  assign code_s = $signed({{(32-CODE_W){1'b0}}, code_r});
  assign p0_s   = 32'(p0);
  assign p1_s   = 32'(p1);
  assign prod   = (mv_hi - mv_lo) * (code_s - p1_s);
  assign span_w = DS_W'(p0_s - p1_s);
  assign span_mag  = span_w[DS_W-1] ? DS_W'(-span_w) : DS_W'(span_w);
  assign span_zero = (span_w == '0);

  // Post-interpolation: sign, offset, clamp, ratio dividend
  logic [DIV_W-1:0] quo;
  logic fin;
  logic signed [31:0] q_s, volt;
  logic [31:0] volt_c;
  logic [DVS_W-1:0] rat_num, rat_den;
  logic [DIV_W-1:0] scaled;

  assign q_s     = neg_r ? -$signed(quo[31:0]) : $signed(quo[31:0]);
  assign volt    = q_s + mv_lo;
  assign volt_c  = volt[31] ? 32'd0 : 32'(volt);
  assign rat_num = ratio_r[2*DVS_W-1:DVS_W];
  assign rat_den = ratio_r[DVS_W-1:0];
  assign scaled  = DIV_W'(round_scale(volt_c, 16'(rat_den), 16'(rat_num)));

  // Shared divider
  logic div_go1, div_go2, div_start;
  logic [DIV_W-1:0] div_dvd;
  logic [DS_W-1:0]  div_dvs;

  assign div_go1   = (state == ST_PREP) && !span_zero;
  assign div_go2   = (state == ST_DIV1) && fin && !bypass && (rat_num != '0);
  assign div_start = div_go1 || div_go2;
  assign div_dvd   = (state == ST_PREP) ? DIV_W'(mag32(prod)) : scaled;
  assign div_dvs   = (state == ST_PREP) ? span_mag : DS_W'(rat_num);

  adc_seq_div #(.DVD_W(DIV_W), .DS_W(DS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dvd(div_dvd), .dvs(div_dvs), .quo(quo), .fin(fin));

  logic accept;
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; code_r <= '0; chan_r <= '0; ratio_r <= '0;
      neg_r <= 1'b0; err_r <= 1'b0; res_r <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          code_r <= in_code; chan_r <= in_chan; ratio_r <= in_ratio;
          state  <= ST_PREP;
        end
        ST_PREP: begin
          neg_r <= prod[31] ^ span_w[DS_W-1];
          if (span_zero) begin
            res_r <= '0; err_r <= 1'b1; state <= ST_DONE;
          end else begin
            state <= ST_DIV1;
          end
        end
        ST_DIV1: if (fin) begin
          if (bypass) begin
            res_r <= DIV_W'(volt_c); err_r <= 1'b0; state <= ST_DONE;
          end else if (rat_num == '0) begin
            res_r <= '0; err_r <= 1'b1; state <= ST_DONE;
          end else begin
            state <= ST_DIV2;
          end
        end
        ST_DIV2: if (fin) begin
          res_r <= quo; err_r <= 1'b0; state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_mv    = res_r;
  assign out_err   = err_r;

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R10
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7 R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_mv == '0));

  // R5
  bypass_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV2) |-> !bypass);

endmodule

// File: tb/sim_adc_volt_conv.sv
`timescale 1ns/1ps
module sim_adc_volt_conv;
  localparam int DW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_load = 1'b0;
  logic [15:0] cal_big_word = 16'h0, cal_small_word = 16'h0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_code = '0;
  logic [4:0] in_chan = '0;
  logic [31:0] in_ratio = '0;
  logic out_valid;
  logic [DW-1:0] out_mv;
  logic out_err;

  always #2 clk = ~clk;

  adc_volt_conv u0 (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load),
    .cal_big_word(cal_big_word), .cal_small_word(cal_small_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code),
    .in_chan(in_chan), .in_ratio(in_ratio), .out_valid(out_valid),
    .out_mv(out_mv), .out_err(out_err));

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  logic [15:0] cb = 16'h8080, cs = 16'h8080;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint pt(input int b, input int nom);
    return longint'((b + nom - 128) * 4);
  endfunction

  task automatic model(input int code, input int ch, input logic [31:0] ratio,
                       output longint v, output bit e, output int lat);
    bit big;
    longint a0, a1, hv, lv, q, volt, num, den;
    big = (ch == 5);
    a0 = big ? pt(int'(cb[7:0]), 856) : pt(int'(cs[7:0]), 833);
    a1 = big ? pt(int'(cb[15:8]), 733) : pt(int'(cs[15:8]), 80);
    hv = big ? 4200 : 1000;
    lv = big ? 3600 : 100;
    if (a0 == a1) begin v = 0; e = 1'b1; lat = 1; return; end
    q = ((hv - lv) * (longint'(code) - a1)) / (a0 - a1);
    volt = q + lv;
    if (volt < 0) volt = 0;
    if (ch == 5 || ch == 1) begin v = volt; e = 1'b0; lat = DW + 2; return; end
    num = longint'(ratio[31:16]);
    den = longint'(ratio[15:0]);
    if (num == 0) begin v = 0; e = 1'b1; lat = DW + 2; return; end
    v = (volt * den + num / 2) / num;
    e = 1'b0;
    lat = 2 * DW + 3;
  endtask

  task automatic load_cal(input logic [15:0] b, input logic [15:0] s);
    @(negedge clk);
    cal_load = 1'b1; cal_big_word = b; cal_small_word = s;
    @(negedge clk);
    cal_load = 1'b0; cal_big_word = ~b; cal_small_word = ~s;
    cb = b; cs = s;
  endtask

  task automatic conv(input int code, input int ch, input logic [31:0] ratio,
                      input bit junk, input string req);
    longint ev; bit ee; int el; int n; bit busy_ok;
    model(code, ch, ratio, ev, ee, el);
    @(negedge clk);
    in_valid = 1'b1; in_code = 12'(code); in_chan = 5'(ch); in_ratio = ratio;
    @(posedge clk);
    n = 0;
    busy_ok = 1'b1;
    @(negedge clk);
    if (junk) begin
      in_code = ~12'(code); in_chan = 5'd7; in_ratio = 32'h0003_0001;
    end else begin
      in_valid = 1'b0;
    end
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (out_valid || n > 300) break;
      if (in_ready) busy_ok = 1'b0;
    end
    in_valid = 1'b0;
    chk(out_mv == DW'(ev), req, longint'(out_mv), ev);
    chk(out_err == ee, {req, " err"}, longint'(out_err), longint'(ee));
    chk(n == el, "R10 latency", longint'(n), longint'(el));
    if (junk) chk(busy_ok, "R9 ready low while busy", longint'(busy_ok), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] cal_b [3];
    logic [15:0] cal_s [3];
    int chans [5];
    logic [31:0] rats [5];
    cal_b[0] = 16'h8080; cal_s[0] = 16'h8080;
    cal_b[1] = 16'h9A70; cal_s[1] = 16'hFF10;
    cal_b[2] = 16'h20E0; cal_s[2] = 16'h40C8;
    chans[0] = 1;  rats[0] = 32'h0000_0000;
    chans[1] = 5;  rats[1] = 32'h0001_0001;
    chans[2] = 0;  rats[2] = {16'd1000, 16'd1955};
    chans[3] = 14; rats[3] = {16'd68, 16'd900};
    chans[4] = 21; rats[4] = {16'd3, 16'd8};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    // R1 nominal points before any load: small line code 3332 -> 1000 mV
    conv(3332, 1, 32'h0, 1'b0, "R1 nominal small point0");
    conv(3424, 5, 32'h0, 1'b0, "R1 nominal big point0");
    // R2 words presented without the strobe are not taken
    @(negedge clk); cal_big_word = 16'h7B00; cal_small_word = 16'hFFFF;
    conv(2932, 5, 32'h0, 1'b0, "R2 word ignored without load");

    // Sweep: R3 R4 R5 R6 across trims
    for (int k = 0; k < 3; k++) begin
      load_cal(cal_b[k], cal_s[k]);
      for (int c = 0; c < 5; c++) begin
        for (int code = 0; code < 4096; code += 97)
          conv(code, chans[c], rats[c], 1'b0, "R3 R4 R5 R6 sweep");
      end
    end

    // R4 clamp: small point1 pushed high, code 0 gives a negative line value
    load_cal(16'h8080, 16'hFF80);
    conv(0, 1, 32'h0, 1'b0, "R4 clamp to zero");
    // R3 truncation toward zero on a negative product
    conv(300, 1, 32'h0, 1'b0, "R3 truncate toward zero");
    // R6 rounding with a ratio that leaves a half remainder
    conv(2000, 2, {16'd2, 16'd3}, 1'b0, "R6 round to nearest");
    // R8 zero numerator on a ratio channel
    conv(2000, 2, 32'h0000_0007, 1'b0, "R8 zero numerator");
    // R8 ratio word has no effect on the direct channels
    conv(2000, 1, 32'h0000_0007, 1'b0, "R8 bypass ignores ratio");
    conv(3000, 5, 32'hFFFF_0000, 1'b0, "R8 bypass ignores ratio big");
    // R7 zero span on the big line (b1 = b0 + 123)
    load_cal(16'h7B00, 16'h8080);
    conv(1234, 5, 32'h0, 1'b0, "R7 zero span");
    conv(1234, 1, 32'h0, 1'b0, "R7 other line unaffected");
    // R9 inputs held busy during conversion are ignored
    load_cal(16'h8080, 16'h8080);
    conv(1500, 14, {16'd68, 16'd900}, 1'b1, "R9 busy inputs ignored");
    conv(2500, 1, 32'h0, 1'b1, "R9 busy inputs ignored bypass");
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 single-cycle valid", longint'(out_valid), 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule